// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block tells a DDR3-style memory controller when to issue auto-refresh commands. An interval timer advances on an enable input and adds one unit of refresh debt each time a full average refresh interval has passed. The interval is halved while the high-temperature flag is set. Debt is kept as a count of postponed refreshes that never exceeds eight.

While debt is pending the block raises a low-priority refresh request, which the command arbiter may serve at a convenient moment. Once eight refreshes are outstanding, the request becomes urgent, and no further debt accrues until one is served. If any bank is open, the block first asks for a precharge-all and holds the bus for the row-precharge time. After each granted refresh it holds the command bus for the refresh cycle time. It enters and leaves self-refresh on strobes, and it freezes the debt while the device refreshes itself. The arbiter therefore resumes after exit with the same number of refreshes owed.

Top module: `refresh_sched`

## Requirements
- R1: After synchronous reset the debt is 0, no request is raised, the bus hold is low and the block is not in self-refresh.
- R2: At normal temperature one unit of debt is added after every IVL_CYC clock cycles in which the tick enable is high. Cycles with the enable low do not advance the timer.
- R3: While the high-temperature flag is high, the accrual period is IVL_CYC/2 enabled cycles.
- R4: Debt never exceeds DEBT_MAX (8) and changes by at most one per cycle. At DEBT_MAX no further debt accrues until a refresh is granted.
- R5: A refresh request is lazy while debt is 1 to 7 and urgent exactly when debt is 8. The two are never high together, and no request is raised while debt is 0.
- R6: With debt pending and the bank-idle input low, the block raises the precharge request and no refresh request. A grant of it holds the bus for TRP_CYC cycles, after which the refresh request appears with debt unchanged.
- R7: A grant while a refresh request is high lowers debt by one at the same clock edge. The bus hold is then high for exactly TRFC_CYC cycles, and no request is raised during that time.
- R8: A grant while no request is raised has no effect on debt or the bus hold.
- R9: A self-refresh entry strobe is accepted when no bus hold is in progress, and it takes priority over a grant in the same cycle. In self-refresh no request is raised, no debt accrues, grants are ignored and debt is held.
- R10: After the self-refresh exit strobe, accrual resumes from the held debt, and the combined debt stays capped at DEBT_MAX.
- R11: A self-refresh entry strobe that arrives while the bus hold is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Advances the interval timer when high |
| hot_i | input | 1 | High-temperature flag; halves the interval |
| banks_idle_i | input | 1 | High when all banks are precharged |
| grant_i | input | 1 | One-cycle grant of the currently raised request |
| sr_enter_i | input | 1 | Self-refresh entry strobe |
| sr_exit_i | input | 1 | Self-refresh exit strobe |
| req_lazy_o | output | 1 | Low-priority refresh request |
| req_urgent_o | output | 1 | Urgent refresh request (debt at cap) |
| pre_req_o | output | 1 | Precharge-all request before refresh |
| bus_hold_o | output | 1 | Only NOP or deselect may be driven |
| in_sr_o | output | 1 | Block is in self-refresh |
| debt_o | output | DEBT_W (4) | Outstanding refresh count |

## Verification
The bench builds the block with IVL_CYC = 8, TRP_CYC = 3 and TRFC_CYC = 5, so a debt of eight builds up within about seventy cycles. With these values, urgent escalation with grants withheld, the halved interval and the exact hold windows can each be measured edge by edge. The interval is even, so the halved period is an exact four cycles. The hold times differ from each other and from the interval, so a swapped or off-by-one counter gives a different cycle count.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_REQ,
        ST_TRP,
        ST_REF_REQ,
        ST_TRFC,
        ST_SELF
    } seq_state_e;

    typedef struct packed {
        logic lazy;
        logic urgent;
        logic pre;
        logic hold;
    } cmd_out_t;

    // Accrual period in cycles for the current temperature range.
    function automatic int unsigned period_for(int unsigned base, logic hot);
        int unsigned half;
        half = (base / 2 < 1) ? 1 : base / 2;
        return hot ? half : base;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_ivl_timer.sv
module ref_ivl_timer
    import refsch_pkg::*;
#(
    parameter int IVL_CYC = 6240
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic hot_i,
    input  logic full_i,
    output logic accrue_o
);
    localparam int CW = $clog2(IVL_CYC + 1);
    localparam logic [CW-1:0] LIM_NORM = CW'(period_for(IVL_CYC, 1'b0) - 1);
    localparam logic [CW-1:0] LIM_HOT  = CW'(period_for(IVL_CYC, 1'b1) - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          at_end;

    assign lim      = hot_i ? LIM_HOT : LIM_NORM;
    assign at_end   = (cnt_q >= lim);
    assign accrue_o = run_i && at_end && !full_i;

    // At the cap the timer parks on its terminal count until debt drops.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (at_end) begin
                if (!full_i) cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    a_r4_no_accrue_stopped: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> !accrue_o);

endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
    parameter int DEBT_MAX = 8,
    localparam int DW = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accrue_i,
    input  logic          retire_i,
    output logic [DW-1:0] debt_o,
    output logic          full_o,
    output logic          any_o
);
    localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

    logic [DW-1:0] debt_q;
    logic          inc, dec;

    assign full_o = (debt_q == CAP);
    assign any_o  = (debt_q != '0);
    assign inc    = accrue_i && !full_o;
    assign dec    = retire_i && any_o;
    assign debt_o = debt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   debt_q <= debt_q + 1'b1;
                2'b01:   debt_q <= debt_q - 1'b1;
                default: debt_q <= debt_q;
            endcase
        end
    end

    a_r4_debt_cap: assert property (@(posedge clk) disable iff (rst)
        debt_q <= CAP);

    a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
        (accrue_i || retire_i) |=> (debt_q == $past(debt_q))
            || (debt_q == $past(debt_q) + 1'b1)
            || (debt_q + 1'b1 == $past(debt_q)));

endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
    import refsch_pkg::*;
#(
    parameter int TRP_CYC  = 11,
    parameter int TRFC_CYC = 128
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     debt_any_i,
    input  logic     debt_full_i,
    input  logic     banks_idle_i,
    input  logic     grant_i,
    input  logic     sr_enter_i,
    input  logic     sr_exit_i,
    output logic     retire_o,
    output logic     in_sr_o,
    output cmd_out_t cmd_o
);
    localparam int TW = $clog2(max2(TRP_CYC, TRFC_CYC) + 1);
    localparam logic [TW-1:0] TRP_LOAD  = TW'(TRP_CYC - 1);
    localparam logic [TW-1:0] TRFC_LOAD = TW'(TRFC_CYC - 1);

    seq_state_e    state_q, state_n;
    logic [TW-1:0] wcnt_q, wcnt_n;

    always_comb begin
        state_n = state_q;
        wcnt_n  = wcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sr_enter_i)      state_n = ST_SELF;
                else if (debt_any_i) state_n = banks_idle_i ? ST_REF_REQ : ST_PRE_REQ;
            end
            ST_PRE_REQ: begin
                if (sr_enter_i) begin
                    state_n = ST_SELF;
                end else if (grant_i) begin
                    state_n = ST_TRP;
                    wcnt_n  = TRP_LOAD;
                end
            end
            ST_TRP: begin
                if (wcnt_q == '0) state_n = ST_REF_REQ;
                else              wcnt_n  = wcnt_q - 1'b1;
            end
            ST_REF_REQ: begin
                if (sr_enter_i) begin
                    state_n = ST_SELF;
                end else if (grant_i) begin
                    state_n = ST_TRFC;
                    wcnt_n  = TRFC_LOAD;
                end
            end
            ST_TRFC: begin
                if (wcnt_q == '0) state_n = ST_IDLE;
                else              wcnt_n  = wcnt_q - 1'b1;
            end
            ST_SELF: begin
                if (sr_exit_i) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            wcnt_q  <= wcnt_n;
        end
    end

    assign retire_o     = (state_q == ST_REF_REQ) && grant_i && !sr_enter_i;
    assign in_sr_o      = (state_q == ST_SELF);
    assign cmd_o.lazy   = (state_q == ST_REF_REQ) && !debt_full_i;
    assign cmd_o.urgent = (state_q == ST_REF_REQ) && debt_full_i;
    assign cmd_o.pre    = (state_q == ST_PRE_REQ);
    assign cmd_o.hold   = (state_q == ST_TRP) || (state_q == ST_TRFC);

    a_r11_sr_blocked_in_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_o.hold && sr_enter_i) |=> !in_sr_o);

    a_r6_pre_grant_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_o.pre && grant_i && !sr_enter_i) |=> cmd_o.hold && !cmd_o.pre);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsch_pkg::*;
#(
    parameter int IVL_CYC  = 6240,
    parameter int TRP_CYC  = 11,
    parameter int TRFC_CYC = 128,
    parameter int DEBT_MAX = 8,
    localparam int DEBT_W  = $clog2(DEBT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en_i,
    input  logic              hot_i,
    input  logic              banks_idle_i,
    input  logic              grant_i,
    input  logic              sr_enter_i,
    input  logic              sr_exit_i,
    output logic              req_lazy_o,
    output logic              req_urgent_o,
    output logic              pre_req_o,
    output logic              bus_hold_o,
    output logic              in_sr_o,
    output logic [DEBT_W-1:0] debt_o
);
    logic     accrue, retire, full, any, in_sr;
    cmd_out_t cmd;

    ref_ivl_timer #(.IVL_CYC(IVL_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (tick_en_i && !in_sr),
        .hot_i    (hot_i),
        .full_i   (full),
        .accrue_o (accrue)
    );

    ref_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk      (clk),
        .rst      (rst),
        .accrue_i (accrue),
        .retire_i (retire),
        .debt_o   (debt_o),
        .full_o   (full),
        .any_o    (any)
    );

    ref_seq_fsm #(.TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .debt_any_i   (any),
        .debt_full_i  (full),
        .banks_idle_i (banks_idle_i),
        .grant_i      (grant_i),
        .sr_enter_i   (sr_enter_i),
        .sr_exit_i    (sr_exit_i),
        .retire_o     (retire),
        .in_sr_o      (in_sr),
        .cmd_o        (cmd)
    );

    assign req_lazy_o   = cmd.lazy;
    assign req_urgent_o = cmd.urgent;
    assign pre_req_o    = cmd.pre;
    assign bus_hold_o   = cmd.hold;
    assign in_sr_o      = in_sr;

    a_r5_urgent_at_cap: assert property (@(posedge clk) disable iff (rst)
        req_urgent_o |-> (debt_o == DEBT_W'(DEBT_MAX)));

    a_r5_one_request: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_lazy_o, req_urgent_o, pre_req_o}));

    a_r9_sr_debt_held: assert property (@(posedge clk) disable iff (rst)
        in_sr_o |=> $stable(debt_o));

    a_r7_grant_opens_hold: assert property (@(posedge clk) disable iff (rst)
        ((req_lazy_o || req_urgent_o) && grant_i && !sr_enter_i) |=> bus_hold_o);

endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int IVL  = 8;
    localparam int TRP  = 3;
    localparam int TRFC = 5;
    localparam int MAXD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 0, hot = 0, banks_idle = 1, grant = 0, sr_enter = 0, sr_exit = 0;
    logic req_lazy, req_urgent, pre_req, bus_hold, in_sr;
    logic [3:0] debt;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    refresh_sched #(.IVL_CYC(IVL), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .DEBT_MAX(MAXD)) u_refresh_sched (
        .clk(clk), .rst(rst), .tick_en_i(tick_en), .hot_i(hot), .banks_idle_i(banks_idle),
        .grant_i(grant), .sr_enter_i(sr_enter), .sr_exit_i(sr_exit),
        .req_lazy_o(req_lazy), .req_urgent_o(req_urgent), .pre_req_o(pre_req),
        .bus_hold_o(bus_hold), .in_sr_o(in_sr), .debt_o(debt)
    );

    function automatic int exp_period(bit h);
        return h ? IVL / 2 : IVL;
    endfunction

    function automatic bit exp_urgent(int d);
        return d == MAXD;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse_grant();
        grant = 1'b1; cyc(); grant = 1'b0;
    endtask

    task automatic pulse_sr_enter();
        sr_enter = 1'b1; cyc(); sr_enter = 1'b0;
    endtask

    task automatic pulse_sr_exit();
        sr_exit = 1'b1; cyc(); sr_exit = 1'b0;
    endtask

    function automatic bit any_req();
        return req_lazy || req_urgent || pre_req;
    endfunction

    task automatic drain();
        tick_en = 1'b0;
        banks_idle = 1'b1;
        while (debt != 0) begin
            if (any_req()) pulse_grant();
            else cyc();
        end
        repeat (TRFC + 2) cyc();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int prev;
        void'($urandom(32'd4242));
        repeat (3) cyc();
        rst = 1'b0;
        // R1 reset state
        chk("R1 debt", debt, 0);
        chk("R1 requests", {req_lazy, req_urgent, pre_req}, 0);
        chk("R1 hold", bus_hold, 0);
        chk("R1 self-refresh", in_sr, 0);

        // R2 first accrual after IVL enabled cycles
        tick_en = 1'b1;
        n = 0;
        do begin cyc(); n++; end while (debt == 0);
        chk("R2 first period", n, exp_period(0));
        n = 0;
        do begin cyc(); n++; end while (debt == 1);
        chk("R2 second period", n, exp_period(0));
        // R5 lazy while 1..7, urgent exactly at 8 (grants withheld)
        while (debt < MAXD) begin
            if (debt >= 2) begin
                chk("R5 lazy below cap", req_lazy, 1);
                chk("R5 no urgent below cap", req_urgent, 0);
            end
            cyc();
        end
        chk("R5 urgent at cap", req_urgent, exp_urgent(debt));
        chk("R5 lazy off at cap", req_lazy, 0);
        repeat (4 * IVL) cyc();
        chk("R4 debt capped", debt, MAXD);
        chk("R4 urgent stays", req_urgent, 1);

        // R7 grant retires one and holds for TRFC
        pulse_grant();
        chk("R7 debt after grant", debt, MAXD - 1);
        n = 0;
        while (bus_hold) begin
            n++;
            if (any_req()) chk("R7 no request in hold", 1, 0);
            cyc();
        end
        chk("R7 hold length", n, TRFC);

        // R8 grant with no request
        drain();
        pulse_grant();
        chk("R8 debt unchanged", debt, 0);
        chk("R8 no hold", bus_hold, 0);
        n = 0;
        repeat (2 * IVL) begin cyc(); if (any_req()) n++; end
        chk("R5 no request at zero debt", n, 0);

        // R3 halved interval when hot, then back to normal
        tick_en = 1'b1; hot = 1'b1;
        prev = debt;
        while (debt == prev) cyc();
        n = 0; prev = debt;
        do begin cyc(); n++; end while (debt == prev);
        chk("R3 hot period", n, exp_period(1));
        hot = 1'b0;
        n = 0; prev = debt;
        do begin cyc(); n++; end while (debt == prev);
        chk("R2 normal period after hot", n, exp_period(0));
        drain();

        // R6 precharge first when banks open
        banks_idle = 1'b0; tick_en = 1'b1;
        while (debt == 0) cyc();
        tick_en = 1'b0;
        while (!pre_req) cyc();
        chk("R6 precharge request", pre_req, 1);
        chk("R6 no refresh request", req_lazy | req_urgent, 0);
        pulse_grant();
        n = 0;
        while (bus_hold) begin n++; cyc(); end
        chk("R6 tRP hold length", n, TRP);
        chk("R6 refresh follows", req_lazy, 1);
        chk("R6 debt kept", debt, 1);
        banks_idle = 1'b1;
        pulse_grant();
        chk("R7 debt retired", debt, 0);
        repeat (TRFC + 2) cyc();

        // R9 / R10 self-refresh carries debt
        tick_en = 1'b1;
        while (debt != 3) cyc();
        tick_en = 1'b0;
        while (!req_lazy) cyc();
        pulse_sr_enter();
        chk("R9 in self-refresh", in_sr, 1);
        chk("R9 no request in self-refresh", req_lazy | req_urgent | pre_req, 0);
        tick_en = 1'b1;
        repeat (4 * IVL) cyc();
        chk("R9 no accrual in self-refresh", debt, 3);
        pulse_grant();
        chk("R9 grant ignored in self-refresh", debt, 3);
        pulse_sr_exit();
        chk("R10 exited", in_sr, 0);
        chk("R10 debt carried", debt, 3);
        n = 0;
        while (debt != MAXD && n < 8 * IVL) begin cyc(); n++; end
        repeat (3 * IVL) cyc();
        chk("R10 combined cap", debt, MAXD);
        chk("R10 urgent after exit", req_urgent, 1);

        // R11 entry strobe ignored during hold
        pulse_grant();
        chk("R11 hold active", bus_hold, 1);
        pulse_sr_enter();
        chk("R11 entry ignored", in_sr, 0);
        repeat (TRFC + 2) cyc();
        chk("R11 still out of self-refresh", in_sr, 0);

        // Random phase with invariant checks
        begin
            int pd;
            bit p_sr;
            bit p_grant_ref;
            pd = debt; p_sr = in_sr; p_grant_ref = 0;
            for (int i = 0; i < 4000; i++) begin
                cyc();
                if (debt > MAXD) chk("R4 random cap", debt, MAXD);
                if (debt > pd + 1 || debt + 1 < pd) chk("R4 random step", debt, pd);
                if (req_urgent && !exp_urgent(debt)) chk("R5 random urgent", debt, MAXD);
                if (req_lazy && (debt == 0 || debt >= MAXD)) chk("R5 random lazy", debt, 1);
                if ((req_lazy + req_urgent + pre_req) > 1) chk("R5 random exclusive", 2, 1);
                if (bus_hold && any_req()) chk("R7 random hold quiet", 1, 0);
                if (p_grant_ref && !bus_hold) chk("R7 random hold after grant", bus_hold, 1);
                if (in_sr && any_req()) chk("R9 random sr quiet", 1, 0);
                if (p_sr && debt != pd) chk("R9 random sr held", debt, pd);
                n_chk++;
                pd = debt; p_sr = in_sr;
                grant = 0; sr_enter = 0; sr_exit = 0;
                tick_en = ($urandom % 4) != 0;
                if ($urandom % 16 == 0) hot = ~hot;
                banks_idle = ($urandom % 3) != 0;
                sr_enter = ($urandom % 97) == 0;
                sr_exit = in_sr && (($urandom % 13) == 0);
                grant = any_req() && (($urandom % 3) == 0);
                p_grant_ref = grant && (req_lazy || req_urgent) && !sr_enter;
            end
            grant = 0; sr_enter = 0; sr_exit = 0;
        end
        finish_run();
    end
endmodule